// File: doc/BRIEF.md
# Dual-I/O Serial Flash Read Engine

This block is the target-side read path of a serial flash. A bus host selects it with an active-low select, clocks it with SCK in either SPI Mode 0 or Mode 3, and sends an 8-bit command, a 24-bit address and, for some commands, dummy clocks. The block then streams bytes from an on-chip array. Four commands are decoded. The first is a plain read with no dummy clocks. The second is a fast read with one dummy byte. The third returns its data on two lines. The fourth also takes its address on two lines and has a four-clock dummy phase.

The SPI pins are oversampled by a system clock. SCK, select and the two data pins pass through the same synchronizer, so they stay aligned with each other. Output data changes after each falling SCK edge, and commands and addresses are taken on each rising SCK edge, most significant bit first. The array is reached through a synchronous byte-read port: a read strobe with an address goes out, and the byte comes back one clock later. The block fetches one byte ahead, so the next byte is always ready before the current byte runs out. The host must hold each SCK phase for at least SYNC_STAGES+3 system clocks.

Top module: `sfr_read_engine`

## Requirements
- R1: After reset, sio_oe_o is 00, mem_rd_o is 0 and mem_addr_o is 0. Once cs_ni has been high for SYNC_STAGES+1 system clocks, sio_oe_o is 00 again, whatever state the transfer was in.
- R2: Command 8'h03 takes 24 address bits on sio_i[0], one per rising SCK edge. The falling SCK edge after the last address bit drives bit 7 of the byte at that address on SIO1, and the remaining bits follow MSB first, one per falling edge.
- R3: Command 8'h0B works like R2, but 8 dummy clocks come between the last address bit and the first data bit.
- R4: Command 8'h3B takes its address on sio_i[0] as in R2 and has 8 dummy clocks. Each data clock then carries two bits: SIO1 (sio_o[1]) carries bits 7,5,3,1 and SIO0 (sio_o[0]) carries bits 6,4,2,0. A byte takes 4 clocks.
- R5: Command 8'hBB takes its address two bits per rising edge, 12 clocks in all. sio_i[1] carries the higher bit of each pair, so A23 comes on sio_i[1] and A22 on sio_i[0] in the first clock. The values of the 4 dummy clocks that follow are ignored, and data comes out as in R4.
- R6: In sio_oe_o, bit 1 enables SIO1 and bit 0 enables SIO0. The value is 00 during the command, address and dummy phases. In the data phase it is 10 for single-line commands and 11 for two-line commands. It is never 01.
- R7: The read address increments after every byte. It wraps from 2^MEM_AW-1 (7FFFFh by default) to 0. Address bits above MEM_AW are ignored.
- R8: Raising cs_ni at any point, even in the middle of the address, ends the command. The next selection decodes a new command from its first bit.
- R9: For an opcode other than the four above, the block drives no pad and issues no array read until cs_ni goes high.
- R10: mem_rd_o is a one-clock pulse. mem_addr_o changes only together with it. A pulse is issued for the start address, and another each time a data-phase falling edge starts a new byte; each of these fetches the byte after the one being started.
- R11: Mode 3 transfers, where SCK idles high, give the same data as Mode 0. The first falling edge after selection shifts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the SPI pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Active-low chip select |
| sio_i | input | 2 | Pad inputs of SIO1 (bit 1) and SIO0 (bit 0) |
| sio_o | output | 2 | Pad output values of SIO1 and SIO0 |
| sio_oe_o | output | 2 | Pad output enables of SIO1 and SIO0 |
| mem_addr_o | output | MEM_AW | Array byte address |
| mem_rd_o | output | 1 | Array read strobe, one clock wide |
| mem_data_i | input | 8 | Array byte, valid the clock after the strobe |

## Verification
The array model returns a byte that is a hash of its address. Each read command is run from several start addresses, so a wrong address lane, a reversed bit pair or a missing dummy clock shows up as a wrong byte. Single-line and two-line reads are compared lane by lane on the pad enables, which separates a data-width error from an ordering error. Runs that cross the top address show whether the wrap is correct, and an address with high bits set shows whether those bits are masked. Aborts in the middle of the address and in the middle of a byte, an unknown opcode and Mode 3 transfers show whether state clears on deselect and whether the idle clock level is handled.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  localparam int unsigned CMD_W = 8;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned BYTE_W = 8;

  localparam logic [CMD_W-1:0] OP_READ = 8'h03;
  localparam logic [CMD_W-1:0] OP_FAST = 8'h0B;
  localparam logic [CMD_W-1:0] OP_DOUT = 8'h3B;
  localparam logic [CMD_W-1:0] OP_DIO  = 8'hBB;

  localparam logic [3:0] DUMMY_SGL = 4'd8;
  localparam logic [3:0] DUMMY_DUAL = 4'd4;

  typedef enum logic [2:0] {PH_CMD, PH_ADDR, PH_DUMMY, PH_DATA, PH_SKIP} phase_e;

  typedef struct packed {
    logic       valid;
    logic       dual_addr;
    logic       dual_data;
    logic [3:0] dummy;
  } cmd_cfg_t;

  function automatic cmd_cfg_t decode_cmd(input logic [CMD_W-1:0] op);
    cmd_cfg_t c;
    c = '0;
    case (op)
      OP_READ: c.valid = 1'b1;
      OP_FAST: begin c.valid = 1'b1; c.dummy = DUMMY_SGL; end
      OP_DOUT: begin c.valid = 1'b1; c.dual_data = 1'b1; c.dummy = DUMMY_SGL; end
      OP_DIO:  begin
        c.valid = 1'b1; c.dual_addr = 1'b1; c.dual_data = 1'b1; c.dummy = DUMMY_DUAL;
      end
      default: c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/sfr_sync_edge.sv
module sfr_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       cs_ni,
  input  logic [1:0] sio_i,
  output logic       sel_o,
  output logic       rise_o,
  output logic       fall_o,
  output logic [1:0] sio_o
);
  // {cs_n, sck, sio1, sio0} travel together so they stay aligned
  logic [STAGES-1:0][3:0] pipe_q;
  logic                   sck_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q     <= {STAGES{4'b1000}};
      sck_last_q <= 1'b0;
    end else begin
      pipe_q[0] <= {cs_ni, sck_i, sio_i};
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
      sck_last_q <= pipe_q[STAGES-1][2];
    end
  end

  assign sel_o  = ~pipe_q[STAGES-1][3];
  assign rise_o = pipe_q[STAGES-1][2] & ~sck_last_q;
  assign fall_o = ~pipe_q[STAGES-1][2] & sck_last_q;
  assign sio_o  = pipe_q[STAGES-1][1:0];
endmodule

// File: rtl/sfr_cmd_ctrl.sv
module sfr_cmd_ctrl
  import sfr_pkg::*;
#(
  parameter int unsigned MEM_AW = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              rise_i,
  input  logic [1:0]        sio_i,
  output phase_e            phase_o,
  output logic              dual_data_o,
  output logic              addr_vld_o,
  output logic [MEM_AW-1:0] addr_o
);
  localparam int unsigned CNT_W = $clog2(ADDR_W);
  localparam logic [CNT_W-1:0] LAST_CMD  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] LAST_SGL  = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] LAST_DUAL = CNT_W'(ADDR_W / 2 - 1);

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [MEM_AW-1:0] sh_q, sh_nxt;
  cmd_cfg_t          cfg_q, cfg_nxt;
  logic              vld_q;
  logic [CNT_W-1:0]  addr_last;

  // address bits above MEM_AW fall off the top of the shifter
  always_comb begin
    if (phase_q == PH_ADDR && cfg_q.dual_addr) sh_nxt = {sh_q[MEM_AW-3:0], sio_i};
    else                                       sh_nxt = {sh_q[MEM_AW-2:0], sio_i[0]};
    cfg_nxt   = decode_cmd(sh_nxt[CMD_W-1:0]);
    addr_last = cfg_q.dual_addr ? LAST_DUAL : LAST_SGL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      cfg_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (!sel_i) begin
        phase_q <= PH_CMD;
        cnt_q   <= '0;
        cfg_q   <= '0;
      end else if (rise_i) begin
        case (phase_q)
          PH_CMD: begin
            sh_q  <= sh_nxt;
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == LAST_CMD) begin
              cnt_q   <= '0;
              cfg_q   <= cfg_nxt;
              phase_q <= cfg_nxt.valid ? PH_ADDR : PH_SKIP;
            end
          end
          PH_ADDR: begin
            sh_q  <= sh_nxt;
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == addr_last) begin
              cnt_q   <= '0;
              vld_q   <= 1'b1;
              phase_q <= (cfg_q.dummy == '0) ? PH_DATA : PH_DUMMY;
            end
          end
          PH_DUMMY: begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q == CNT_W'(cfg_q.dummy - 4'd1)) begin
              cnt_q   <= '0;
              phase_q <= PH_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign phase_o     = phase_q;
  assign dual_data_o = cfg_q.dual_data;
  assign addr_vld_o  = vld_q;
  assign addr_o      = sh_q;
endmodule

// File: rtl/sfr_out_path.sv
module sfr_out_path
  import sfr_pkg::*;
#(
  parameter int unsigned MEM_AW = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              fall_i,
  input  phase_e            phase_i,
  input  logic              dual_i,
  input  logic              addr_vld_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic [BYTE_W-1:0] mem_data_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic [1:0]        sio_o,
  output logic [1:0]        sio_oe_o
);
  localparam int unsigned POS_W = $clog2(BYTE_W);

  logic [MEM_AW-1:0] addr_q;
  logic              rd_q;
  logic [BYTE_W-1:0] byte_q, cur;
  logic [POS_W-1:0]  pos_q;
  logic [1:0]        pad_q;
  logic              drv_q;

  // a new byte is taken from the array port at bit position zero
  assign cur = (pos_q == '0) ? mem_data_i : byte_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
      byte_q <= '0;
      pos_q  <= '0;
      pad_q  <= '0;
      drv_q  <= 1'b0;
    end else begin
      rd_q <= 1'b0;
      if (!sel_i) begin
        pos_q <= '0;
        pad_q <= '0;
        drv_q <= 1'b0;
      end else if (addr_vld_i) begin
        addr_q <= addr_i;
        rd_q   <= 1'b1;
      end else if (fall_i && phase_i == PH_DATA) begin
        drv_q <= 1'b1;
        if (dual_i) begin
          pad_q  <= cur[BYTE_W-1 -: 2];
          byte_q <= cur << 2;
          pos_q  <= pos_q + POS_W'(2);
        end else begin
          pad_q  <= {cur[BYTE_W-1], 1'b0};
          byte_q <= cur << 1;
          pos_q  <= pos_q + POS_W'(1);
        end
        if (pos_q == '0) begin
          addr_q <= addr_q + MEM_AW'(1);
          rd_q   <= 1'b1;
        end
      end
    end
  end

  assign mem_addr_o = addr_q;
  assign mem_rd_o   = rd_q;
  assign sio_o      = pad_q;
  assign sio_oe_o   = drv_q ? {1'b1, dual_i} : 2'b00;
endmodule

// File: rtl/sfr_read_engine.sv
module sfr_read_engine
  import sfr_pkg::*;
#(
  parameter int unsigned MEM_AW      = 19,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic [1:0]        sio_i,
  output logic [1:0]        sio_o,
  output logic [1:0]        sio_oe_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_data_i
);
  logic              sel, rise, fall, dual, addr_vld;
  logic [1:0]        sio_s;
  phase_e            phase;
  logic [MEM_AW-1:0] addr;

  sfr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .sck_i (sck_i), .cs_ni (cs_ni), .sio_i (sio_i),
    .sel_o (sel), .rise_o (rise), .fall_o (fall), .sio_o (sio_s)
  );

  sfr_cmd_ctrl #(.MEM_AW(MEM_AW)) u_ctrl (
    .clk_i (clk_i), .rst_ni (rst_ni), .sel_i (sel), .rise_i (rise), .sio_i (sio_s),
    .phase_o (phase), .dual_data_o (dual), .addr_vld_o (addr_vld), .addr_o (addr)
  );

  sfr_out_path #(.MEM_AW(MEM_AW)) u_out (
    .clk_i (clk_i), .rst_ni (rst_ni), .sel_i (sel), .fall_i (fall), .phase_i (phase),
    .dual_i (dual), .addr_vld_i (addr_vld), .addr_i (addr), .mem_data_i (mem_data_i),
    .mem_addr_o (mem_addr_o), .mem_rd_o (mem_rd_o), .sio_o (sio_o), .sio_oe_o (sio_oe_o)
  );
endmodule

// File: rtl/sfr_read_engine_chk.sv
module sfr_read_engine_chk #(
  parameter int unsigned MEM_AW      = 19,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic [1:0]        sio_oe_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              mem_rd_o
);
  localparam int unsigned LIM = SYNC_STAGES + 1;
  localparam int unsigned CW  = $clog2(LIM + 2);

  logic [CW-1:0] hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      hi_cnt_q <= '0;
    else if (!cs_ni)                  hi_cnt_q <= '0;
    else if (hi_cnt_q < CW'(LIM))     hi_cnt_q <= hi_cnt_q + CW'(1);
  end

  assert_deselect_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && hi_cnt_q >= CW'(LIM)) |-> (sio_oe_o == 2'b00));

  assert_no_sio0_alone_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sio_oe_o != 2'b01);

  assert_rd_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  assert_addr_moves_with_rd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> mem_rd_o);
endmodule

bind sfr_read_engine sfr_read_engine_chk #(.MEM_AW(MEM_AW), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .cs_ni (cs_ni), .sio_oe_o (sio_oe_o),
  .mem_addr_o (mem_addr_o), .mem_rd_o (mem_rd_o)
);

// File: tb/tb_sfr_read_engine.sv
module tb_sfr_read_engine;
  localparam int MEM_AW = 19;
  localparam int HP = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n, sck, cs_n;
  logic [1:0]        m_sio, sio_o, sio_oe;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_rd;
  logic [7:0]        mem_q;

  int n_chk = 0, n_fail = 0, rd_cnt = 0;

  sfr_read_engine #(.MEM_AW(MEM_AW), .SYNC_STAGES(2)) dut (
    .clk_i (clk), .rst_ni (rst_n), .sck_i (sck), .cs_ni (cs_n), .sio_i (m_sio),
    .sio_o (sio_o), .sio_oe_o (sio_oe), .mem_addr_o (mem_addr), .mem_rd_o (mem_rd),
    .mem_data_i (mem_q)
  );

  function automatic logic [7:0] pat(input logic [MEM_AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ (8'(a[MEM_AW-1:16]) * 8'd29) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_q  <= pat(mem_addr);
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_byte;
  event       obs_ev;

  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) chk(1'b0, "R2", "unexpected byte", obs_byte, 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(obs_byte == e, t, "data byte", obs_byte, e);
      end
    end
  end

  task automatic spi_clk(input logic [1:0] din, output logic [1:0] dout, output logic [1:0] oe);
    sck = 1'b0;
    m_sio = din;
    repeat (HP) @(negedge clk);
    dout = sio_o;
    oe = sio_oe;
    sck = 1'b1;
    repeat (HP) @(negedge clk);
  endtask

  task automatic deselect(input bit cpol);
    if (!cpol) begin
      sck = 1'b0;
      repeat (HP) @(negedge clk);
    end
    cs_n = 1'b1;
    m_sio = 2'b00;
    repeat (4 * HP) @(negedge clk);
  endtask

  task automatic read_txn(input bit cpol, input logic [7:0] op, input logic [23:0] a,
                          input int n, input int tail, input string req);
    bit dual_a, dual_d, quiet, lanes;
    int dmy, rd_base;
    logic [1:0] d, oe;
    logic [7:0] got;
    dual_a = (op == 8'hBB);
    dual_d = (op == 8'hBB) || (op == 8'h3B);
    dmy = (op == 8'h03) ? 0 : (dual_a ? 4 : 8);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(pat(a[MEM_AW-1:0] + MEM_AW'(i)));
      tag_q.push_back(req);
    end
    rd_base = rd_cnt;
    quiet = 1'b1;
    sck = cpol;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int b = 7; b >= 0; b--) begin spi_clk({1'b0, op[b]}, d, oe); quiet &= (oe == 2'b00); end
    if (dual_a) for (int k = 11; k >= 0; k--) begin
      spi_clk({a[2*k+1], a[2*k]}, d, oe); quiet &= (oe == 2'b00);
    end
    else for (int k = 23; k >= 0; k--) begin spi_clk({1'b0, a[k]}, d, oe); quiet &= (oe == 2'b00); end
    for (int k = 0; k < dmy; k++) begin spi_clk(2'b11, d, oe); quiet &= (oe == 2'b00); end
    chk(quiet, "R6", "pads released before data", 0, 0);
    for (int i = 0; i < n; i++) begin
      got = '0;
      lanes = 1'b1;
      if (dual_d) for (int k = 0; k < 4; k++) begin
        spi_clk(2'b00, d, oe); got = {got[5:0], d}; lanes &= (oe == 2'b11);
      end
      else for (int k = 0; k < 8; k++) begin
        spi_clk(2'b00, d, oe); got = {got[6:0], d[1]}; lanes &= (oe == 2'b10);
      end
      chk(lanes, dual_d ? "R4" : "R6", "data lane enables", oe, dual_d ? 3 : 2);
      obs_byte = got;
      -> obs_ev;
      @(negedge clk);
    end
    for (int k = 0; k < tail; k++) spi_clk(2'b00, d, oe);
    deselect(cpol);
    chk(sio_oe == 2'b00, "R1", "pads after deselect", sio_oe, 0);
    chk(exp_q.size() == 0, req, "scoreboard drained", exp_q.size(), 0);
    // mode 0 ends with one more falling edge, which starts byte n
    if (tail == 0 && n > 0)
      chk(rd_cnt - rd_base == n + 1 + (cpol ? 0 : 1), "R10", "array reads",
          rd_cnt - rd_base, n + 1 + (cpol ? 0 : 1));
  endtask

  task automatic abort_in_addr();
    logic [1:0] d, oe;
    sck = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int b = 7; b >= 0; b--) spi_clk({1'b0, 8'h03 >> b}, d, oe);
    for (int k = 0; k < 10; k++) spi_clk(2'b01, d, oe);
    deselect(1'b0);
    chk(sio_oe == 2'b00, "R8", "pads after abort in address", sio_oe, 0);
  endtask

  task automatic unknown_op(input logic [7:0] op);
    logic [1:0] d, oe;
    bit quiet;
    int rd_base;
    quiet = 1'b1;
    rd_base = rd_cnt;
    sck = 1'b0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HP) @(negedge clk);
    for (int b = 7; b >= 0; b--) spi_clk({1'b0, op[b]}, d, oe);
    for (int k = 0; k < 40; k++) begin spi_clk(2'b11, d, oe); quiet &= (oe == 2'b00); end
    deselect(1'b0);
    chk(quiet, "R9", "no pad driven after unknown opcode", 0, 0);
    chk(rd_cnt == rd_base, "R9", "no array read after unknown opcode", rd_cnt - rd_base, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    sck = 1'b0;
    cs_n = 1'b1;
    m_sio = 2'b00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(sio_oe == 2'b00, "R1", "oe after reset", sio_oe, 0);
    chk(mem_rd == 1'b0, "R1", "rd after reset", mem_rd, 0);
    chk(mem_addr == '0, "R1", "addr after reset", mem_addr, 0);

    read_txn(1'b0, 8'h03, 24'h012345, 5, 0, "R2");
    read_txn(1'b0, 8'h0B, 24'h003C00, 4, 0, "R3");
    read_txn(1'b0, 8'h3B, 24'h000100, 6, 0, "R4");
    read_txn(1'b0, 8'h3B, 24'h04A7F3, 3, 0, "R4");
    read_txn(1'b0, 8'hBB, 24'h05A5A4, 6, 0, "R5");
    read_txn(1'b0, 8'hBB, 24'h02D0B7, 3, 0, "R5");
    read_txn(1'b0, 8'h03, 24'h07FFFE, 4, 0, "R7");
    read_txn(1'b0, 8'hBB, 24'h07FFFF, 3, 0, "R7");
    read_txn(1'b0, 8'h0B, 24'hFABCDE, 3, 0, "R7");
    read_txn(1'b1, 8'h0B, 24'h0316AC, 3, 0, "R11");
    read_txn(1'b1, 8'hBB, 24'h0612F0, 3, 0, "R11");
    read_txn(1'b1, 8'h03, 24'h07FFFF, 2, 0, "R11");
    abort_in_addr();
    read_txn(1'b0, 8'h03, 24'h00ABCD, 2, 0, "R8");
    read_txn(1'b0, 8'h0B, 24'h011111, 1, 3, "R1");
    read_txn(1'b0, 8'h03, 24'h022222, 2, 0, "R8");
    unknown_op(8'h9F);
    unknown_op(8'h05);
    read_txn(1'b0, 8'h3B, 24'h033333, 2, 0, "R9");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule